// File: doc/BRIEF.md
# Packed Single-Precision Compare and Min/Max Unit

This block compares and selects between two packed vectors of single-precision floating-point values. Each 64-bit operand carries two lanes. On every accepted operation both lanes are handled in parallel, and the lanes are independent of each other. Three of the operations are compares: equal, greater-than and greater-or-equal. A compare writes a full-width mask into each lane. The other two operations, minimum and maximum, pass one of the two input words through to each lane unchanged.

The unit sits in a SIMD execution pipeline. It accepts a new operation on any cycle that the valid strobe is high, and it delivers each result exactly two cycles later. It has no stall and no exceptions. It produces no status or rounding. Zero of either sign counts as one value, and denormal inputs are read as zero of their own sign. A NaN on either side gives a fixed, repeatable answer: compares read false, and minimum and maximum return the second operand.

Top module: `pfcmp_unit`

## Requirements
- R1: Lane 0 is held in bits 31:0 and lane 1 in bits 63:32 of every operand and of the result, and each lane's result depends only on that lane's inputs.
- R2: The opcode input selects the operation: 0 = equal, 1 = greater-than (a > b), 2 = greater-or-equal (a >= b), 3 = minimum, 4 = maximum; opcodes 5, 6 and 7 yield an all-zero result.
- R3: A compare writes 32'hFFFF_FFFF into a lane whose condition holds and 32'h0000_0000 into a lane whose condition fails.
- R4: Each lane is read as an IEEE single (sign bit 31, biased exponent bits 30:23, significand bits 22:0), and compares follow signed numeric order, including negative values and both infinities.
- R5: Positive zero and negative zero compare as equal, and neither is greater than the other.
- R6: A lane whose exponent field is zero is treated as zero of the same sign, so a denormal equals zero and is smaller than the smallest positive normal.
- R7: Minimum returns a when a < b and otherwise b; maximum returns a when a > b and otherwise b; the result is the exact input bit pattern, so on a tie the second operand is returned.
- R8: A lane in which either input is a NaN (exponent all ones, significand nonzero) returns all zeros for every compare and returns the second operand's bits for minimum and maximum.
- R9: out_valid rises exactly two cycles after each cycle in which in_valid is high and stays low two cycles after each cycle in which it is low; back-to-back operations each yield their own result in order.
- R10: While reset is asserted and right after it, out_valid and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_data | output | 64 | Packed result |

## Verification
The compares are driven with pairs that differ only in sign, pairs of negatives, infinities against the largest finite values, and exact equality. These tell correct signed ordering apart from a plain unsigned word compare, and they separate greater-than from greater-or-equal. Signed zeros and denormals against zeros and the smallest normal expose a missing flush or a sign-sensitive zero test. Vectors where the two lanes disagree catch swapped or shared lanes. Ties and NaNs under minimum and maximum confirm that the second operand is returned bit for bit. A back-to-back burst followed by a bubble pins down the two-cycle latency.

// File: rtl/pfcmp_pkg.sv
package pfcmp_pkg;

   typedef enum logic [2:0] {
      OP_EQ  = 3'd0,
      OP_GT  = 3'd1,
      OP_GE  = 3'd2,
      OP_MIN = 3'd3,
      OP_MAX = 3'd4
   } pf_op_e;

   function automatic logic op_is_cmp(input logic [2:0] op);
      return (op == OP_EQ) || (op == OP_GT) || (op == OP_GE);
   endfunction

   function automatic logic op_is_sel(input logic [2:0] op);
      return (op == OP_MIN) || (op == OP_MAX);
   endfunction

endpackage

// File: rtl/pfcmp_lane_cmp.sv
module pfcmp_lane_cmp #(
   parameter int EXP_W        = 8,
   parameter int MAN_W        = 23,
   parameter bit FLUSH_DENORM = 1'b1,
   localparam int W           = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         eq,
   output logic         gt,
   output logic         nan
);

   logic a_zmag, b_zmag;
   logic [W-2:0] a_mag, b_mag;
   logic [W-1:0] a_key, b_key;
   logic a_nan, b_nan;

   // zero-magnitude detection: flush variant ignores the significand
   generate
      if (FLUSH_DENORM) begin : g_flush
         assign a_zmag = (a[W-2:MAN_W] == '0);
         assign b_zmag = (b[W-2:MAN_W] == '0);
      end else begin : g_keep
         assign a_zmag = (a[W-2:0] == '0);
         assign b_zmag = (b[W-2:0] == '0);
      end
   endgenerate

   assign a_mag = a_zmag ? '0 : a[W-2:0];
   assign b_mag = b_zmag ? '0 : b[W-2:0];

   // map sign-magnitude onto an unsigned ordering key; both zeros share one key
   function automatic logic [W-1:0] order_key(input logic s, input logic [W-2:0] m);
      if (m == '0)
         return {1'b1, {(W-1){1'b0}}};
      else if (s)
         return {1'b0, ~m};
      else
         return {1'b1, m};
   endfunction

   assign a_key = order_key(a[W-1], a_mag);
   assign b_key = order_key(b[W-1], b_mag);

   assign a_nan = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
   assign b_nan = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
   assign nan   = a_nan | b_nan;

   assign eq = !nan && (a_key == b_key);
   assign gt = !nan && (a_key >  b_key);

endmodule

// File: rtl/pfcmp_lane_sel.sv
module pfcmp_lane_sel
   import pfcmp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         eq,
   input  logic         gt,
   input  logic         nan,
   output logic [W-1:0] res
);

   logic a_lt;
   assign a_lt = !nan && !gt && !eq;

   always_comb begin
      case (op)
         OP_EQ:   res = {W{eq}};
         OP_GT:   res = {W{gt}};
         OP_GE:   res = {W{eq | gt}};
         OP_MIN:  res = a_lt ? a : b;
         OP_MAX:  res = (!nan && gt) ? a : b;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/pfcmp_unit.sv
module pfcmp_unit
   import pfcmp_pkg::*;
#(
   parameter int LANES        = 2,
   parameter int EXP_W        = 8,
   parameter int MAN_W        = 23,
   parameter bit FLUSH_DENORM = 1'b1,
   localparam int LANE_W      = 1 + EXP_W + MAN_W,
   localparam int DATA_W      = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   // elaboration-time parameter checks
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("pfcmp_unit: LANES must be at least 1");
      end
      if (EXP_W < 2) begin : g_bad_exp
         $error("pfcmp_unit: EXP_W must be at least 2");
      end
      if (MAN_W < 1) begin : g_bad_man
         $error("pfcmp_unit: MAN_W must be at least 1");
      end
   endgenerate

   logic [LANES-1:0]  c_eq, c_gt, c_nan;
   logic              s1_valid;
   logic [2:0]        s1_op;
   logic [DATA_W-1:0] s1_a, s1_b;
   logic [LANES-1:0]  s1_eq, s1_gt, s1_nan;
   logic [DATA_W-1:0] sel_res;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         pfcmp_lane_cmp #(
            .EXP_W(EXP_W), .MAN_W(MAN_W), .FLUSH_DENORM(FLUSH_DENORM)
         ) u_cmp (
            .a  (in_a[i*LANE_W +: LANE_W]),
            .b  (in_b[i*LANE_W +: LANE_W]),
            .eq (c_eq[i]),
            .gt (c_gt[i]),
            .nan(c_nan[i])
         );

         pfcmp_lane_sel #(.W(LANE_W)) u_sel (
            .op (s1_op),
            .a  (s1_a[i*LANE_W +: LANE_W]),
            .b  (s1_b[i*LANE_W +: LANE_W]),
            .eq (s1_eq[i]),
            .gt (s1_gt[i]),
            .nan(s1_nan[i]),
            .res(sel_res[i*LANE_W +: LANE_W])
         );

         // R3: compare lanes are full masks
         p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && op_is_cmp($past(s1_op))) |->
               (out_data[i*LANE_W +: LANE_W] == '0 || out_data[i*LANE_W +: LANE_W] == '1));

         // R7: min/max output is one of the two stored inputs
         p_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && op_is_sel($past(s1_op))) |->
               (out_data[i*LANE_W +: LANE_W] == $past(s1_a[i*LANE_W +: LANE_W]) ||
                out_data[i*LANE_W +: LANE_W] == $past(s1_b[i*LANE_W +: LANE_W])));

         // R8: NaN lanes never compare true
         p_nan_false_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(s1_nan[i]) && op_is_cmp($past(s1_op))) |->
               (out_data[i*LANE_W +: LANE_W] == '0));

         // R5: zeros of any sign are equal once staged
         p_zero_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_a[i*LANE_W +: LANE_W-1] == '0 && in_b[i*LANE_W +: LANE_W-1] == '0)
               |=> (s1_eq[i] && !s1_gt[i]));
      end
   endgenerate

   // stage 1: operands, opcode and per-lane compare flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= '0;
         s1_a     <= '0;
         s1_b     <= '0;
         s1_eq    <= '0;
         s1_gt    <= '0;
         s1_nan   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_op  <= in_op;
            s1_a   <= in_a;
            s1_b   <= in_b;
            s1_eq  <= c_eq;
            s1_gt  <= c_gt;
            s1_nan <= c_nan;
         end
      end
   end

   // stage 2: selected result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid)
            out_data <= sel_res;
      end
   end

   // R9: fixed two-cycle latency in both directions
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

endmodule

// File: tb/pfcmp_unit_test.sv
`timescale 1ns/1ps
module pfcmp_unit_test;

   localparam logic [31:0] P1   = 32'h3F80_0000;
   localparam logic [31:0] P2   = 32'h4000_0000;
   localparam logic [31:0] N1   = 32'hBF80_0000;
   localparam logic [31:0] N2   = 32'hC000_0000;
   localparam logic [31:0] PZ   = 32'h0000_0000;
   localparam logic [31:0] NZ   = 32'h8000_0000;
   localparam logic [31:0] PINF = 32'h7F80_0000;
   localparam logic [31:0] NINF = 32'hFF80_0000;
   localparam logic [31:0] PMAX = 32'h7F7F_FFFF;
   localparam logic [31:0] NMAX = 32'hFF7F_FFFF;
   localparam logic [31:0] QNAN = 32'h7FC0_0000;
   localparam logic [31:0] ONES = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = 3'd0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic [63:0] out_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pfcmp_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === exp, tag, {out_valid, out_data}, {1'b1, exp});
   endtask

   task automatic t_reset;
      chk(out_valid === 1'b0 && out_data === 64'h0, "R10 reset state",
          {out_valid, out_data}, 65'h0);
   endtask

   task automatic t_order;
      run_op(3'd0, {P2, P1}, {P2, N1}, {ONES, 32'h0}, "R1 R3 lanes independent eq");
      run_op(3'd1, {N1, P2}, {N2, P1}, {ONES, ONES}, "R4 gt negatives and positives");
      run_op(3'd1, {N2, P1}, {N1, P2}, 64'h0, "R4 gt false both lanes");
      run_op(3'd1, {PINF, NINF}, {PMAX, NMAX}, {ONES, 32'h0}, "R4 gt infinities");
      run_op(3'd2, {P1, P1}, {P1, P2}, {ONES, 32'h0}, "R2 ge on equal and less");
      run_op(3'd1, {P1, N1}, {N1, P1}, {ONES, 32'h0}, "R4 gt sign only");
   endtask

   task automatic t_zero;
      run_op(3'd0, {PZ, NZ}, {NZ, PZ}, {ONES, ONES}, "R5 signed zeros equal");
      run_op(3'd1, {PZ, NZ}, {NZ, PZ}, 64'h0, "R5 signed zeros not greater");
   endtask

   task automatic t_denorm;
      run_op(3'd0, {32'h0000_0001, 32'h8000_0005}, {PZ, PZ}, {ONES, ONES}, "R6 denormal equals zero");
      run_op(3'd1, {32'h0080_0000, 32'h0000_0001}, {32'h007F_FFFF, PZ}, {ONES, 32'h0},
             "R6 min normal above denormal");
   endtask

   task automatic t_minmax;
      run_op(3'd3, {P2, N1}, {P1, N2}, {P1, N2}, "R7 min");
      run_op(3'd4, {P2, N1}, {P1, N2}, {P2, N1}, "R7 max");
      run_op(3'd3, {PZ, 32'h0000_0001}, {NZ, PZ}, {NZ, PZ}, "R7 min tie returns b");
      run_op(3'd4, {N1, P1}, {N1, P2}, {N1, P2}, "R7 max tie and less");
   endtask

   task automatic t_nan;
      run_op(3'd0, {QNAN, QNAN}, {QNAN, P1}, 64'h0, "R8 nan eq false");
      run_op(3'd2, {QNAN, P1}, {P1, QNAN}, 64'h0, "R8 nan ge false");
      run_op(3'd3, {QNAN, P1}, {P2, QNAN}, {P2, QNAN}, "R8 nan min returns b");
      run_op(3'd4, {QNAN, P2}, {P1, QNAN}, {P1, QNAN}, "R8 nan max returns b");
   endtask

   task automatic t_bad_op;
      run_op(3'd5, {P1, P1}, {P1, P1}, 64'h0, "R2 opcode 5 zero");
      run_op(3'd7, {P2, N1}, {P1, N2}, 64'h0, "R2 opcode 7 zero");
   endtask

   task automatic t_pipeline;
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'd1; in_a = {P2, P2}; in_b = {P1, P1};
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 not ready after one cycle", {64'h0, out_valid}, 65'h0);
      in_op = 3'd3; in_a = {P2, N1}; in_b = {P1, N2};
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === {ONES, ONES}, "R9 first of burst",
          {out_valid, out_data}, {1'b1, ONES, ONES});
      in_op = 3'd0; in_a = {P1, P2}; in_b = {P1, P1};
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid === 1'b1 && out_data === {P1, N2}, "R9 second of burst",
          {out_valid, out_data}, {1'b1, P1, N2});
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === {ONES, 32'h0}, "R9 third of burst",
          {out_valid, out_data}, {1'b1, ONES, 32'h0});
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 bubble follows", {64'h0, out_valid}, 65'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_zero();
      t_denorm();
      t_minmax();
      t_nan();
      t_bad_op();
      t_pipeline();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule